// File: doc/BRIEF.md
# Half-Bridge Current Guard

This block sits between the PWM comparator of one half-bridge and its gate drivers. It turns the raw PWM level into complementary high-side and low-side enables with a programmable dead band. It also watches an overcurrent comparator flag and a loop-saturation flag.

The guard has two protection modes, chosen by `latch_mode`. In limiting mode, an overcurrent event forces the bridge to the opposite switch state for the rest of the current PWM frame. A saturating up/down counter tracks how many recent frames contained such events; when it reaches its ceiling, the bridge is turned off for good. In latched mode, the first overcurrent turns the bridge off at once. Either kind of shutdown holds until reset and is reported on `fault`.

While the loop is saturated, the guard injects a short opposite-polarity pulse on every fourth frame, which keeps the switching alive at a quarter of the frame rate. It also emits a clip pulse at the start of every saturated frame.

The control state machine has three states:
- `ST_FOLLOW`: the bridge tracks `pwm_in`.
- `ST_FORCED`: the bridge holds the flipped level that was captured at the overcurrent.
- `ST_TRIPPED`: both enables are off.

Its transitions are:
- FOLLOW→FORCED on an overcurrent in limiting mode.
- FORCED→FOLLOW on `frame_start` without a new overcurrent.
- FORCED→FORCED (level reloaded) on `frame_start` together with an overcurrent.
- FOLLOW/FORCED→TRIPPED on an overcurrent in latched mode, or when the overload count reaches its ceiling.
- TRIPPED→TRIPPED until reset.

Top module: `hbg_current_guard`

## Requirements
- R1: In `ST_FOLLOW` with no overcurrent and no keep-alive pulse, the steady enables follow `pwm_in`: a 1 gives `hs_en`=1 and `ls_en`=0, and a 0 gives `hs_en`=0 and `ls_en`=1.
- R2: `hs_en` and `ls_en` are never both 1. After the demanded side changes, both enables stay 0 for exactly DEAD_CYC+1 clocks before the new side turns on.
- R3: In limiting mode (`latch_mode`=0), `oc_flag` high for one clock flips the demanded side to the inverse of `pwm_in` in that same clock. The flipped side is then held whatever `pwm_in` does, and `fault` stays 0.
- R4: The forced flip ends at the next `frame_start` pulse, after which the enables follow `pwm_in` again.
- R5: An overload count goes up by one at each `frame_start` that closes a frame containing an overcurrent, and down by one at each `frame_start` that closes a clean frame. The count never goes below 0. When it reaches OVL_MAX, `fault` rises one clock later.
- R6: Once `fault` is 1, both enables are 0 and `fault` stays 1 whatever the inputs do, until `rst_n` is asserted.
- R7: In latched mode (`latch_mode`=1), the first `oc_flag` clock turns both enables off at the next clock edge and raises `fault` at the same edge.
- R8: While `clip_flag` is 1, every fourth `frame_start` (counted from the rise of `clip_flag`) inverts the demand for KA_CYC clocks. With DEAD_CYC dead clocks, the opposite enable is therefore on for KA_CYC-DEAD_CYC-1 clocks in that frame and for none in the other three frames.
- R9: At each `frame_start` with `clip_flag`=1, `clip_pulse` goes high for CLIP_CYC clocks. A clock with `clip_flag`=0 clears it by the next edge.
- R10: During reset, `hs_en`, `ls_en`, `fault` and `clip_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-clock pulse at the start of each PWM frame |
| pwm_in | input | 1 | Raw PWM level from the comparator (1 = high side) |
| oc_flag | input | 1 | Overcurrent comparator flag |
| clip_flag | input | 1 | Loop saturation / clipping flag |
| latch_mode | input | 1 | 1 = shut down on first overcurrent; 0 = cycle-by-cycle limiting |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Channel shut down and latched |
| clip_pulse | output | 1 | Clip indication pulse |

## Verification
The bench builds the guard with OVL_MAX=6, DEAD_CYC=1, KA_CYC=6 and CLIP_CYC=3, using 16-clock frames. With these values, an overload trip needs only a few frames, so a mixed run of hit and clean frames can show the count falling as well as rising, and the trip frame can be pinned exactly. A keep-alive pulse of six clocks against one dead clock leaves a four-clock visible pulse whose frame position can be counted. A three-clock clip pulse fits well inside a frame.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

    typedef enum logic [1:0] {
        ST_FOLLOW  = 2'd0,
        ST_FORCED  = 2'd1,
        ST_TRIPPED = 2'd2
    } guard_state_t;

endpackage

// File: rtl/hbg_overload_ctr.sv
`timescale 1ns/1ps
module hbg_overload_ctr #(
    parameter int unsigned OVL_MAX = 1035
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic oc_hit,
    output logic trip
);
    localparam int unsigned CW = $clog2(OVL_MAX + 1);
    localparam logic [CW-1:0] MAX_V = CW'(OVL_MAX);

    logic [CW-1:0] cnt_q;
    logic          hit_q;

    // A frame's verdict is taken at the frame_start that closes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else if (frame_start) begin
            if (hit_q && cnt_q != MAX_V)
                cnt_q <= cnt_q + 1'b1;
            else if (!hit_q && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            hit_q <= oc_hit;
        end else if (oc_hit) begin
            hit_q <= 1'b1;
        end
    end

    assign trip = (cnt_q == MAX_V);

endmodule

// File: rtl/hbg_pulse_timer.sv
`timescale 1ns/1ps
module hbg_pulse_timer #(
    parameter int unsigned HOLD_CYC = 8,
    parameter int unsigned EVERY    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic enable,
    output logic active
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

    logic          fire;
    logic [HW-1:0] hold_q;

    generate
        if (EVERY > 1) begin : g_div
            localparam int unsigned FW = $clog2(EVERY);
            localparam logic [FW-1:0] LAST = FW'(EVERY - 1);
            logic [FW-1:0] fc_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    fc_q <= '0;
                else if (!enable)
                    fc_q <= '0;
                else if (frame_start)
                    fc_q <= (fc_q == LAST) ? '0 : fc_q + 1'b1;
            end

            assign fire = frame_start & enable & (fc_q == LAST);
        end else begin : g_each
            assign fire = frame_start & enable;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (!enable)
            hold_q <= '0;
        else if (fire)
            hold_q <= HOLD_V;
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign active = (hold_q != '0);

endmodule

// File: rtl/hbg_deadband.sv
`timescale 1ns/1ps
module hbg_deadband #(
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hiz,
    input  logic demand,
    output logic hs_en,
    output logic ls_en
);
    localparam int unsigned DW = $clog2(DEAD_CYC + 2);
    localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

    logic          side_q;
    logic [DW-1:0] wait_q;
    logic          hs_q;
    logic          ls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q <= 1'b0;
            wait_q <= DEAD_V;
            hs_q   <= 1'b0;
            ls_q   <= 1'b0;
        end else if (hiz) begin
            wait_q <= DEAD_V;
            hs_q   <= 1'b0;
            ls_q   <= 1'b0;
        end else if (demand != side_q) begin
            side_q <= demand;
            wait_q <= DEAD_V;
            hs_q   <= 1'b0;
            ls_q   <= 1'b0;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
            hs_q   <= 1'b0;
            ls_q   <= 1'b0;
        end else begin
            hs_q   <= side_q;
            ls_q   <= ~side_q;
        end
    end

    assign hs_en = hs_q;
    assign ls_en = ls_q;

endmodule

// File: rtl/hbg_current_guard.sv
`timescale 1ns/1ps
module hbg_current_guard
    import hbg_pkg::*;
#(
    parameter int unsigned OVL_MAX  = 1035,
    parameter int unsigned DEAD_CYC = 4,
    parameter int unsigned KA_CYC   = 16,
    parameter int unsigned KA_EVERY = 4,
    parameter int unsigned CLIP_CYC = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic pwm_in,
    input  logic oc_flag,
    input  logic clip_flag,
    input  logic latch_mode,
    output logic hs_en,
    output logic ls_en,
    output logic fault,
    output logic clip_pulse
);
    guard_state_t state_q, state_d;
    logic flip_q, flip_d;
    logic trip, ka_on, hiz, demand, oc_live;

    assign oc_live = oc_flag & (state_q != ST_TRIPPED);

    hbg_overload_ctr #(.OVL_MAX(OVL_MAX)) u_ovl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .oc_hit(oc_live), .trip(trip)
    );

    hbg_pulse_timer #(.HOLD_CYC(KA_CYC), .EVERY(KA_EVERY)) u_ka (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .enable(clip_flag), .active(ka_on)
    );

    hbg_pulse_timer #(.HOLD_CYC(CLIP_CYC), .EVERY(1)) u_clip (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .enable(clip_flag), .active(clip_pulse)
    );

    hbg_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
        .clk(clk), .rst_n(rst_n), .hiz(hiz), .demand(demand),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FOLLOW;
            flip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flip_q  <= flip_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        flip_d  = flip_q;
        unique case (state_q)
            ST_FOLLOW: begin
                if (trip || (oc_flag && latch_mode)) begin
                    state_d = ST_TRIPPED;
                end else if (oc_flag) begin
                    state_d = ST_FORCED;
                    flip_d  = ~pwm_in;
                end
            end
            ST_FORCED: begin
                if (trip || (oc_flag && latch_mode)) begin
                    state_d = ST_TRIPPED;
                end else if (frame_start && oc_flag) begin
                    flip_d  = ~pwm_in;
                end else if (frame_start) begin
                    state_d = ST_FOLLOW;
                end
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
            default: begin
                state_d = ST_TRIPPED;
            end
        endcase
    end

    // Drive demand and Hi-Z request
    always_comb begin
        hiz    = 1'b0;
        demand = 1'b0;
        unique case (state_q)
            ST_FOLLOW: begin
                hiz    = trip | (oc_flag & latch_mode);
                demand = oc_flag ? ~pwm_in : (pwm_in ^ ka_on);
            end
            ST_FORCED: begin
                hiz = trip | (oc_flag & latch_mode);
                if (frame_start && oc_flag)
                    demand = ~pwm_in;
                else if (frame_start)
                    demand = pwm_in ^ ka_on;
                else
                    demand = flip_q;
            end
            ST_TRIPPED: begin
                hiz    = 1'b1;
                demand = 1'b0;
            end
            default: begin
                hiz    = 1'b1;
                demand = 1'b0;
            end
        endcase
    end

    assign fault = (state_q == ST_TRIPPED);

endmodule

// File: rtl/hbg_guard_chk.sv
`timescale 1ns/1ps
module hbg_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic oc_flag,
    input logic clip_flag,
    input logic latch_mode,
    input logic hs_en,
    input logic ls_en,
    input logic fault,
    input logic clip_pulse
);
    // R2
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R2
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    // R2
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R6
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_en && !ls_en));

    // R7
    latch_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && oc_flag) |=> fault);

    // R9
    clip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clip_flag |=> !clip_pulse);

endmodule

bind hbg_current_guard hbg_guard_chk u_chk (.*);

// File: tb/sim_hbg_current_guard.sv
`timescale 1ns/1ps
module sim_hbg_current_guard;
    localparam int OVL  = 6;
    localparam int DEAD = 1;
    localparam int KA   = 6;
    localparam int CLIPW = 3;
    localparam int FL   = 16;

    // {pwm, expected hs, expected ls}
    localparam logic [2:0] VEC [0:5] = '{3'b001, 3'b110, 3'b001, 3'b110, 3'b110, 3'b001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs = 1'b0, pwm = 1'b0, oc = 1'b0, clip = 1'b0, lmode = 1'b0;
    logic hs, ls, fault, cpulse;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hbg_current_guard #(.OVL_MAX(OVL), .DEAD_CYC(DEAD), .KA_CYC(KA),
                        .KA_EVERY(4), .CLIP_CYC(CLIPW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(fs), .pwm_in(pwm),
        .oc_flag(oc), .clip_flag(clip), .latch_mode(lmode),
        .hs_en(hs), .ls_en(ls), .fault(fault), .clip_pulse(cpulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fs = 0; oc = 0; clip = 0;
        repeat (3) step();
        // R10
        chk({hs, ls, fault, cpulse} == 4'b0000, "R10 reset outputs", {hs, ls, fault, cpulse}, 0);
        rst_n = 1'b1;
        repeat (6) step();
    endtask

    task automatic frame(input bit hit, output int nhs, output int nls, output int ncl);
        nhs = 0; nls = 0; ncl = 0;
        fs = 1'b1;
        step();
        fs = 1'b0;
        nhs += hs; nls += ls; ncl += cpulse;
        for (int i = 1; i < FL; i++) begin
            oc = (hit && i == 4);
            step();
            oc = 1'b0;
            nhs += hs; nls += ls; ncl += cpulse;
        end
    endtask

    initial begin
        int a, b, c;
        pwm = 1'b0; lmode = 1'b0;
        do_reset();

        // R1: table walk
        for (int i = 0; i < 6; i++) begin
            pwm = VEC[i][2];
            repeat (6) step();
            chk(hs == VEC[i][1] && ls == VEC[i][0], "R1 follow pwm", {hs, ls}, {VEC[i][1], VEC[i][0]});
        end

        // R2: dead band on low->high change
        pwm = 1'b0; repeat (6) step();
        pwm = 1'b1;
        step(); chk(!hs && !ls, "R2 dead clock 1", {hs, ls}, 0);
        step(); chk(!hs && !ls, "R2 dead clock 2", {hs, ls}, 0);
        step(); chk(hs && !ls, "R2 high side after gap", {hs, ls}, 2);

        // R3: overcurrent flip holds, no fault
        repeat (4) step();
        oc = 1'b1; step(); oc = 1'b0;
        chk(!hs, "R3 high side drops at once", hs, 0);
        repeat (2) step();
        chk(ls && !hs, "R3 flipped to low side", {hs, ls}, 1);
        repeat (6) step();
        chk(ls && !hs && !fault, "R3 flip held while pwm high", {fault, hs, ls}, 1);

        // R4: cleared at next frame start
        fs = 1'b1; step(); fs = 1'b0;
        repeat (4) step();
        chk(hs && !ls, "R4 follows pwm after frame start", {hs, ls}, 2);

        // R5: overload counter up/down then trip
        do_reset();
        pwm = 1'b1; repeat (4) step();
        repeat (3) frame(1'b1, a, b, c);
        repeat (2) frame(1'b0, a, b, c);
        repeat (5) frame(1'b1, a, b, c);
        chk(!fault, "R5 no trip at count OVL-1", fault, 0);
        fs = 1'b1; step(); fs = 1'b0;
        chk(!fault, "R5 fault not before count reaches max", fault, 0);
        step();
        chk(fault && !hs && !ls, "R5 trip at OVL_MAX", {fault, hs, ls}, 4);

        // R6: latched, ignores inputs
        for (int k = 0; k < 3; k++) begin
            pwm = k[0];
            frame(1'b0, a, b, c);
            chk(fault && a == 0 && b == 0, "R6 stays shut", a + b, 0);
        end

        // R7: latched mode immediate trip
        do_reset();
        lmode = 1'b1; pwm = 1'b1; repeat (6) step();
        chk(hs && !fault, "R7 running before oc", {fault, hs}, 1);
        oc = 1'b1; step(); oc = 1'b0;
        chk(fault && !hs && !ls, "R7 first oc shuts down", {fault, hs, ls}, 4);
        lmode = 1'b0; repeat (10) step();
        chk(fault && !hs && !ls, "R6 latch survives mode change", {fault, hs, ls}, 4);
        do_reset();
        chk(!fault, "R10 reset releases fault", fault, 0);

        // R8 / R9: saturation
        pwm = 1'b1; repeat (6) step();
        clip = 1'b1;
        for (int f = 1; f <= 8; f++) begin
            frame(1'b0, a, b, c);
            if (f % 4 == 0)
                chk(b == KA - DEAD - 1, "R8 keep-alive pulse frame", b, KA - DEAD - 1);
            else
                chk(b == 0, "R8 no pulse in other frames", b, 0);
            chk(c == CLIPW, "R9 clip pulse width", c, CLIPW);
        end
        fs = 1'b1; step(); fs = 1'b0;
        chk(cpulse, "R9 clip pulse starts", cpulse, 1);
        clip = 1'b0; step();
        chk(!cpulse, "R9 clip pulse self-clears", cpulse, 0);
        frame(1'b0, a, b, c);
        chk(c == 0 && b == 0, "R9 R8 nothing when not saturated", c + b, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule